// File: doc/BRIEF.md
# Two-bit saturating outcome predictor

This block keeps a four-level confidence counter for a single binary event, such as whether a branch is taken. Each time an outcome is reported with the update enable raised, the counter steps one level toward the reported direction. It stops at either end of the range, so a long run of one outcome cannot push it past the strongest level. The prediction for the next event is the counter's upper half: the two high levels predict 1 and the two low levels predict 0.

The four levels, from strongest 0 to strongest 1, are stored in two flip-flops with a Gray-style assignment: 00, 01, 11, 10. With this assignment the prediction is simply the high bit, with no decode. Every step between neighbouring levels also flips exactly one bit. A synchronous reset starts the counter at the weak-0 level.

Top module: `sat2_predictor`

## Requirements
- R1: A clock edge with `rst` high sets `state` to 2'b01 (level 1, weak 0), whatever the other inputs are.
- R2: A clock edge with `rst` low and `upd_en` low leaves `state` unchanged, whatever `outcome` is.
- R3: With `rst` low and `upd_en` high, `outcome` = 1 raises the level by one and stops at level 3. The levels are 0=2'b00, 1=2'b01, 2=2'b11 and 3=2'b10, written as {bit1, bit0}.
- R4: With `rst` low and `upd_en` high, `outcome` = 0 lowers the level by one and stops at level 0, using the same encoding.
- R5: `predict` equals `state[1]`. It is 1 at levels 2 and 3 and 0 at levels 0 and 1.
- R6: No clock edge without reset changes more than one bit of `state`.
- R7: For every pair of starting level and `outcome` value, one enabled update gives the same level as an integer counter limited to the range 0 to 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| upd_en | input | 1 | Applies `outcome` on this edge when high |
| outcome | input | 1 | 1 = event happened (count up), 0 = did not (count down) |
| predict | output | 1 | Predicted next outcome |
| state | output | 2 | Current encoded level |

## Verification
The assertions take only two things for granted about the inputs: `upd_en` and `outcome` are known (0 or 1) at every rising edge, and a reset is applied before the state is relied on. Every property is gated by reset, so the state before the first reset is never judged. The bench changes inputs only on the falling edge, applies reset before every scenario, and drives the counter into each starting level through legal enabled updates, never by forcing the state.

// File: rtl/sat2_predictor.sv
module sat2_predictor (
  input  logic       clk,
  input  logic       rst,
  input  logic       upd_en,
  input  logic       outcome,
  output logic       predict,
  output logic [1:0] state
);

  localparam logic [1:0] LVL_WEAK_LOW = 2'b01;

  logic [1:0] cur_q;
  logic [1:0] nxt;

  assign nxt[1]  = (cur_q[1] & ~cur_q[0]) | (cur_q[0] & outcome);
  assign nxt[0]  = outcome ^ cur_q[1];
  assign predict = cur_q[1];
  assign state   = cur_q;

  always_ff @(posedge clk) begin
    if (rst)
      cur_q <= LVL_WEAK_LOW;
    else if (upd_en)
      cur_q <= nxt;
  end

  function automatic int unsigned lvl(input logic [1:0] s);
    case (s)
      2'b00:   return 0;
      2'b01:   return 1;
      2'b11:   return 2;
      default: return 3;
    endcase
  endfunction

  a_r1_reset_level: assert property (@(posedge clk)
    rst |=> state == 2'b01);

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(state));

  a_r3_step_up: assert property (@(posedge clk) disable iff (rst)
    (upd_en && outcome) |=>
      lvl(state) == ((lvl($past(state)) == 3) ? 3 : lvl($past(state)) + 1));

  a_r4_step_down: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !outcome) |=>
      lvl(state) == ((lvl($past(state)) == 0) ? 0 : lvl($past(state)) - 1));

  a_r6_one_bit_move: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $countones(state ^ $past(state)) <= 1);

endmodule

// File: tb/tb_sat2_predictor.sv
`timescale 1ns/1ps
module tb_sat2_predictor;
  logic clk = 1'b0;
  logic rst = 1'b0, upd_en = 1'b0, outcome = 1'b0;
  logic predict;
  logic [1:0] state;
  int checks = 0, failures = 0;
  int model = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sat2_predictor dut (.clk(clk), .rst(rst), .upd_en(upd_en), .outcome(outcome),
                      .predict(predict), .state(state));

  function automatic logic [1:0] enc(input int l);
    case (l)
      0: return 2'b00;
      1: return 2'b01;
      2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic e, input logic o);
    @(negedge clk);
    rst = r; upd_en = e; outcome = o;
    @(posedge clk);
    #1;
    if (r) model = 1;
    else if (e) model = o ? ((model == 3) ? 3 : model + 1) : ((model == 0) ? 0 : model - 1);
  endtask

  task automatic check_state(input string tag);
    chk(tag, state, enc(model));
    chk({tag, " R5 predict"}, {1'b0, predict}, {1'b0, enc(model)[1]});
  endtask

  task automatic t_reset;
    step(1'b1, 1'b1, 1'b1);
    chk("R1 reset level", state, 2'b01);
    chk("R5 predict after reset", {1'b0, predict}, 2'b00);
    step(1'b0, 1'b1, 1'b1);
    step(1'b1, 1'b0, 1'b0);
    chk("R1 reset from level 2", state, 2'b01);
  endtask

  task automatic t_hold;
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b0);
    chk("R2 hold with outcome 0", state, 2'b11);
    step(1'b0, 1'b0, 1'b1);
    chk("R2 hold with outcome 1", state, 2'b11);
  endtask

  task automatic t_walk_up;
    logic [1:0] prev;
    step(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      prev = state;
      step(1'b0, 1'b1, 1'b1);
      check_state("R3 count up");
      chk("R6 single bit change", {1'b0, ($countones(prev ^ state) <= 1) ? 1'b1 : 1'b0}, 2'b01);
    end
    chk("R3 saturate at level 3", state, 2'b10);
  endtask

  task automatic t_walk_down;
    logic [1:0] prev;
    for (int i = 0; i < 5; i++) begin
      prev = state;
      step(1'b0, 1'b1, 1'b0);
      check_state("R4 count down");
      chk("R6 single bit change", {1'b0, ($countones(prev ^ state) <= 1) ? 1'b1 : 1'b0}, 2'b01);
    end
    chk("R4 saturate at level 0", state, 2'b00);
  endtask

  task automatic t_all_pairs;
    for (int l = 0; l < 4; l++) begin
      for (int o = 0; o < 2; o++) begin
        step(1'b1, 1'b0, 1'b0);
        if (l == 0) step(1'b0, 1'b1, 1'b0);
        for (int k = 1; k < l; k++) step(1'b0, 1'b1, 1'b1);
        chk("R7 start level", state, enc(l));
        step(1'b0, 1'b1, o[0]);
        check_state("R7 state/input pair");
      end
    end
  endtask

  initial begin
    step(1'b1, 1'b0, 1'b0);
    t_reset();
    t_hold();
    t_walk_up();
    t_walk_down();
    t_all_pairs();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule